// File: doc/BRIEF.md
# Rank Idle-Timeout Power State Controller

This block keeps track of the power state of one DRAM rank. It sits beside the memory scheduler. It grants accesses while the rank is awake and counts idle cycles once an access completes. When the idle count passes a threshold supplied at run time, it drops the rank into a low-power state. The first threshold leads to power-down, which has a short exit latency. The second threshold leads deeper into self-refresh, which draws much less power but takes far longer to leave.

A request that arrives while the rank is in a low-power state is held. The ready signal stays low for exactly the exit latency of the state being left, counted in clock cycles. A software force input sends the rank straight to self-refresh and keeps it there until an explicit release or an access. Every state change produces a one-cycle strobe that carries the new state code, so time spent in each state can be accumulated outside the block.

Top module: `rank_pwr_fsm`

## Requirements
- R1: Reset is asynchronous and active low. While reset is held and after it is released, the state output reads standby (code 0), ready is high and the strobe is low. The state codes are standby 0, active 1, power-down 2 and self-refresh 3.
- R2: When a request is presented while ready is high (in standby or active), the state is active in the next cycle.
- R3: In the active state, a completion with no new request returns the rank to standby in the next cycle. A completion that coincides with an accepted request keeps the rank active.
- R4: The idle count starts at 0 in the first standby cycle and advances once per cycle. In the cycle where it has reached the power-down threshold with no request pending, the next state is power-down. An accepted request before that point restarts the count from 0.
- R5: The idle count keeps advancing in power-down. Once it has reached the self-refresh threshold (set to at least the power-down threshold) with no request pending, the next state is self-refresh.
- R6: Ready is low in power-down and self-refresh. A request first seen in cycle t in one of these states makes the rank read standby, with ready high, in cycle t + the exit latency of that state. Both exit latencies are parameters of at least 2 cycles. Until then the state code stays at the low-power state.
- R7: A force pulse in standby or power-down, with no request and no exit in progress, moves the rank to self-refresh in the next cycle. In the active state the force input has no effect.
- R8: After a forced entry, self-refresh is left only through a request or a release pulse. Either one starts the self-refresh exit. A release pulse while self-refresh was reached by idling has no effect.
- R9: The strobe is high for exactly the first cycle of each new state, and the new-state output then equals the state output. The strobe is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request from the scheduler, held until granted |
| req_ready | output | 1 | Grant: the rank can take the access this cycle |
| acc_done | input | 1 | The access in flight completes this cycle |
| thr_pd | input | CW | Idle cycles before power-down |
| thr_sr | input | CW | Idle cycles before self-refresh (at least thr_pd) |
| force_sr | input | 1 | Software request for immediate self-refresh |
| release_sr | input | 1 | Software release of a forced self-refresh |
| pstate | output | 2 | Current power state code |
| chg_stb | output | 1 | One-cycle pulse on each state change |
| chg_state | output | 2 | State code entered, valid with chg_stb |

## Verification
A wrong idle count shows at the state port as an entry into power-down or self-refresh one or more cycles early or late. A table of cycle-exact state codes catches it in the first cycle where the rank should have changed state. A wrong exit counter shows as ready rising one cycle off from the latency. A lost forced flag shows as self-refresh being left on a release pulse that should have been ignored, or kept after a release that should have been obeyed. Both of these show up within the same exit window. Strobe faults appear at once as a pulse that does not match the state transition seen in that cycle.

// File: rtl/rank_pwr_pkg.sv
package rank_pwr_pkg;

  typedef enum logic [1:0] {
    PS_STBY = 2'd0,
    PS_ACT  = 2'd1,
    PS_PDN  = 2'd2,
    PS_SREF = 2'd3
  } pstate_e;

  // States in which the rank can take an access without an exit delay
  function automatic logic can_serve(pstate_e s);
    return (s == PS_STBY) || (s == PS_ACT);
  endfunction

  // States in which idle time accumulates
  function automatic logic idles_in(pstate_e s);
    return (s == PS_STBY) || (s == PS_PDN);
  endfunction

endpackage

// File: rtl/rank_idle_ctr.sv
module rank_idle_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (run && cnt != CMAX) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/rank_wake_ctr.sv
module rank_wake_ctr #(
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [WW-1:0] len,   // exit latency minus one
  output logic          busy,
  output logic          done
);

  logic [WW-1:0] cnt;

  assign done = busy && (cnt == WW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= len;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (done) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/rank_pwr_fsm.sv
module rank_pwr_fsm
  import rank_pwr_pkg::*;
#(
  parameter int CW     = 16,
  parameter int LAT_PD = 2,    // power-down exit, cycles (>= 2)
  parameter int LAT_SR = 125   // self-refresh exit, cycles (>= 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          acc_done,
  input  logic [CW-1:0] thr_pd,
  input  logic [CW-1:0] thr_sr,
  input  logic          force_sr,
  input  logic          release_sr,
  output logic [1:0]    pstate,
  output logic          chg_stb,
  output logic [1:0]    chg_state
);

  localparam int LAT_MAX = (LAT_SR > LAT_PD) ? LAT_SR : LAT_PD;
  localparam int WW      = $clog2(LAT_MAX + 1);

  function automatic logic past_thr(input logic [CW-1:0] c, input logic [CW-1:0] t);
    return c >= t;
  endfunction

  function automatic logic [WW-1:0] wake_len(input pstate_e s);
    return (s == PS_SREF) ? WW'(LAT_SR - 1) : WW'(LAT_PD - 1);
  endfunction

  pstate_e       st_q, st_d, chg_st_q;
  logic          forced_q, chg_q;
  logic [CW-1:0] idle_cnt;

  // Named internal events
  logic accept, wake_go, wk_busy, wk_done, force_go, idle_run, pd_due, sr_due;

  assign req_ready = can_serve(st_q);
  assign accept    = req_valid && req_ready;
  assign wake_go   = !wk_busy &&
                     ((st_q == PS_PDN  && req_valid) ||
                      (st_q == PS_SREF && (req_valid || (forced_q && release_sr))));
  assign force_go  = force_sr && !req_valid && !wk_busy && idles_in(st_q);
  assign idle_run  = idles_in(st_q) && !wk_busy;
  assign pd_due    = past_thr(idle_cnt, thr_pd);
  assign sr_due    = past_thr(idle_cnt, thr_sr);

  rank_idle_ctr #(.CW(CW)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (idle_run),
    .clr   (!idle_run),
    .cnt   (idle_cnt)
  );

  rank_wake_ctr #(.WW(WW)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wake_go),
    .len   (wake_len(st_q)),
    .busy  (wk_busy),
    .done  (wk_done)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      PS_STBY: begin
        if (accept)        st_d = PS_ACT;
        else if (force_go) st_d = PS_SREF;
        else if (pd_due)   st_d = PS_PDN;
      end
      PS_ACT: begin
        if (!accept && acc_done) st_d = PS_STBY;
      end
      PS_PDN: begin
        if (wk_done)                              st_d = PS_STBY;
        else if (force_go)                        st_d = PS_SREF;
        else if (!wk_busy && !req_valid && sr_due) st_d = PS_SREF;
      end
      PS_SREF: begin
        if (wk_done) st_d = PS_STBY;
      end
      default: st_d = PS_STBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PS_STBY;
      forced_q <= 1'b0;
      chg_q    <= 1'b0;
      chg_st_q <= PS_STBY;
    end else begin
      st_q     <= st_d;
      chg_q    <= (st_d != st_q);
      chg_st_q <= st_d;
      if (wake_go)       forced_q <= 1'b0;
      else if (force_go) forced_q <= 1'b1;
    end
  end

  assign pstate    = st_q;
  assign chg_stb   = chg_q;
  assign chg_state = chg_st_q;

endmodule

// File: rtl/rank_pwr_chk.sv
module rank_pwr_chk #(
  parameter int CW     = 16,
  parameter int LAT_PD = 2,
  parameter int LAT_SR = 125
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          acc_done,
  input logic          force_sr,
  input logic          release_sr,
  input logic [CW-1:0] thr_pd,
  input logic [CW-1:0] idle_cnt,
  input logic [1:0]    pstate,
  input logic          chg_stb,
  input logic [1:0]    chg_state,
  input logic          wake_go,
  input logic          wk_busy
);

  localparam int LAT_MAX = (LAT_SR > LAT_PD) ? LAT_SR : LAT_PD;
  localparam int KW      = $clog2(LAT_MAX + 1) + 1;

  // Cycles since the last exit began, independent of the exit counter
  logic [KW-1:0] since_wake;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                since_wake <= '0;
    else if (wake_go)                          since_wake <= KW'(1);
    else if (pstate == 2'd0)                   since_wake <= '0;
    else if (since_wake != '0 && since_wake != '1) since_wake <= since_wake + 1'b1;
  end

  p_lp_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd2 || pstate == 2'd3) |-> !req_ready);

  p_pd_exit_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd0 && $past(pstate) == 2'd2) |-> since_wake == KW'(LAT_PD));

  p_sr_exit_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd0 && $past(pstate) == 2'd3) |-> since_wake == KW'(LAT_SR));

  p_grant_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> pstate == 2'd1);

  p_done_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd1 && acc_done && !req_valid) |=> pstate == 2'd0);

  p_pd_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd0 && !req_valid && !force_sr && idle_cnt >= thr_pd) |=> pstate == 2'd2);

  p_force_sr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_sr && !req_valid && !wk_busy && (pstate == 2'd0 || pstate == 2'd2)) |=> pstate == 2'd3);

  p_sr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd3 && !wk_busy && !req_valid && !release_sr) |=> pstate == 2'd3);

  p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chg_stb == (pstate != $past(pstate)));

  p_strobe_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chg_stb |-> chg_state == pstate);

endmodule

bind rank_pwr_fsm rank_pwr_chk #(
  .CW     (CW),
  .LAT_PD (LAT_PD),
  .LAT_SR (LAT_SR)
) u_rank_pwr_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .acc_done   (acc_done),
  .force_sr   (force_sr),
  .release_sr (release_sr),
  .thr_pd     (thr_pd),
  .idle_cnt   (idle_cnt),
  .pstate     (pstate),
  .chg_stb    (chg_stb),
  .chg_state  (chg_state),
  .wake_go    (wake_go),
  .wk_busy    (wk_busy)
);

// File: tb/test_rank_pwr_fsm.sv
module test_rank_pwr_fsm;

  localparam int CW     = 8;
  localparam int LAT_PD = 2;
  localparam int LAT_SR = 6;
  localparam int NV     = 62;

  // Row: {req, done, force, release, state[1:0], ready, strobe}
  // Thresholds 3 (power-down) and 6 (self-refresh).
  localparam logic [7:0] VEC [NV] = '{
    8'b0000_0010, // 0  standby after reset (R1)
    8'b1000_0010, // 1  request granted (R2)
    8'b0000_0111, // 2  active
    8'b0100_0110, // 3  completion (R3)
    8'b0000_0011, // 4  standby, idle 0
    8'b0000_0010, // 5
    8'b1000_0010, // 6  request at idle 2 restarts count (R4)
    8'b0100_0111, // 7
    8'b0000_0011, // 8
    8'b0000_0010, // 9
    8'b0000_0010, // 10
    8'b0000_0010, // 11 idle 3 reaches threshold
    8'b0000_1001, // 12 power-down (R4)
    8'b0000_1000, // 13
    8'b0000_1000, // 14 idle 6
    8'b0000_1101, // 15 self-refresh (R5)
    8'b1000_1100, // 16 request held (R6)
    8'b1000_1100, // 17
    8'b1000_1100, // 18
    8'b1000_1100, // 19
    8'b1000_1100, // 20
    8'b1000_1100, // 21
    8'b1000_0011, // 22 standby after 6 cycles, granted
    8'b0100_0111, // 23
    8'b0000_0011, // 24
    8'b0000_0010, // 25
    8'b0000_0010, // 26
    8'b0000_0010, // 27
    8'b1000_1001, // 28 power-down, request (R6)
    8'b1000_1000, // 29
    8'b1000_0011, // 30 standby after 2 cycles
    8'b1100_0111, // 31 done plus new grant stays active (R3)
    8'b0110_0110, // 32 force ignored while active (R7)
    8'b0010_0011, // 33 force in standby
    8'b0000_1101, // 34 forced self-refresh (R7)
    8'b0000_1100, // 35 held (R8)
    8'b0001_1100, // 36 release starts exit (R8)
    8'b0000_1100, // 37
    8'b0000_1100, // 38
    8'b0000_1100, // 39
    8'b0000_1100, // 40
    8'b0000_1100, // 41
    8'b0000_0011, // 42
    8'b0000_0010, // 43
    8'b0000_0010, // 44
    8'b0000_0010, // 45
    8'b0010_1001, // 46 force from power-down
    8'b1000_1101, // 47 forced self-refresh, access exits
    8'b1000_1100, // 48
    8'b1000_1100, // 49
    8'b1000_1100, // 50
    8'b1000_1100, // 51
    8'b1000_1100, // 52
    8'b0000_0011, // 53
    8'b0000_0010, // 54
    8'b0000_0010, // 55
    8'b0000_0010, // 56
    8'b0000_1001, // 57
    8'b0000_1000, // 58
    8'b0000_1000, // 59
    8'b0001_1101, // 60 release on idle entry ignored (R8)
    8'b0000_1100  // 61
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, acc_done = 1'b0, force_sr = 1'b0, release_sr = 1'b0;
  logic [CW-1:0] thr_pd = 8'd3, thr_sr = 8'd6;
  logic          req_ready, chg_stb;
  logic [1:0]    pstate, chg_state;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  rank_pwr_fsm #(.CW(CW), .LAT_PD(LAT_PD), .LAT_SR(LAT_SR)) i_rank_pwr_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .acc_done(acc_done), .thr_pd(thr_pd), .thr_sr(thr_sr), .force_sr(force_sr),
    .release_sr(release_sr), .pstate(pstate), .chg_stb(chg_stb), .chg_state(chg_state)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 5000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    chk("R1 state in reset", pstate, 0);
    chk("R1 ready in reset", req_ready, 1);
    chk("R1 strobe in reset", chg_stb, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {req_valid, acc_done, force_sr, release_sr} = VEC[i][7:4];
      #1;
      chk($sformatf("row %0d state R2/R3/R4/R5/R6/R7/R8", i), pstate, int'(VEC[i][3:2]));
      chk($sformatf("row %0d ready R6", i), req_ready, int'(VEC[i][1]));
      chk($sformatf("row %0d strobe R9", i), chg_stb, int'(VEC[i][0]));
      if (chg_stb) chk($sformatf("row %0d strobe code R9", i), chg_state, int'(pstate));
      @(negedge clk);
    end
    {req_valid, acc_done, force_sr, release_sr} = 4'b0000;

    // R1: asynchronous reset from self-refresh
    rst_n = 1'b0;
    #1;
    chk("R1 async reset state", pstate, 0);
    chk("R1 async reset ready", req_ready, 1);
    chk("R1 async reset strobe", chg_stb, 0);

    // R4, R5: zero thresholds go down one level per cycle
    thr_pd = 8'd0;
    thr_sr = 8'd0;
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 standby after release", pstate, 0);
    @(negedge clk);
    #1 chk("R4 zero threshold power-down", pstate, 2);
    @(negedge clk);
    #1 chk("R5 zero threshold self-refresh", pstate, 3);
    chk("R6 ready low in self-refresh", req_ready, 0);

    // R6: short request pulse still completes the self-refresh exit
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (LAT_SR - 2) @(negedge clk);
    #1 chk("R6 still self-refresh one cycle before exit", pstate, 3);
    @(negedge clk);
    #1 chk("R6 standby at exit latency", pstate, 0);
    chk("R6 ready at exit latency", req_ready, 1);

    finish_run();
  end

endmodule